// File: doc/BRIEF.md
# Cache Performance Counter Unit

This block counts what happens inside a second-level cache so that software can measure hit rates and access latencies. The cache pipeline drives one event line per event kind (a single-cycle pulse per occurrence) and one qualifier line per latency kind (held high for every cycle that the measured condition lasts). The unit keeps one counter per line. It also keeps a sticky overflow flag per counter and a small control word that starts, stops and zeroes the whole bank.

There are fifteen event lines. Lines 0..3 cover 32-byte accesses: load hit, load miss, store hit, store miss. Lines 4..7 cover all other accesses in the same order. Lines 8 and 9 are prefetch hit and miss. Lines 10, 11 and 12 count maintenance operations issued by address, by entry and by set. Line 13 counts copied-back lines and line 14 counts hits on a pending miss. There are six qualifier lines. Line 0 is high on every bus cycle. Lines 1..4 carry the latency of 32-byte loads, 32-byte stores, other loads and other stores. Line 5 carries the latency of hits on a pending miss.

Software reads the counters over a simple word bus with a registered read port. Any bus master can clear the counters and read them back while the cache runs.

Top module: `l2_perf_unit`

## Requirements
- R1: Event counter n (NUM_EVT counters, EVT_W bits, default 32) adds one on each clock edge where `evt_pulse[n]` is high and counting is enabled, and wraps to zero after all-ones.
- R2: Event counter n is read at byte offset 0x100 + 4*n, zero-extended to 32 bits.
- R3: Cycle counter n (NUM_CYC counters, CYC_W bits, default 48) adds one on each enabled edge where `cyc_qual[n]` is high. Its bits CYC_LO_W-1:0 (default 31:0) are read at 0x180 + 8*n. Its bits CYC_W-1:CYC_LO_W (default 47:32) are read right-aligned at 0x180 + 8*n + 4, and the bits above them read as zero.
- R4: The control word is at 0x70. Bit 0 is the enable and reads back as written. Bit 1 is a write-one clear, is not stored and reads as 0. All other bits read as 0.
- R5: The event overflow map is at 0x74 and the cycle overflow map is at 0x78. Bit n of a map is set on the edge where counter n wraps from all-ones to zero, and it then stays set until a clear.
- R6: A control write with bit 1 set zeroes every counter and both overflow maps on that edge. The enable takes bit 0 of the same write. A clear beats an event or qualifier in the same cycle.
- R7: While the enable is 0, no counter and no overflow bit changes.
- R8: A read with `bus_rd` high returns its word on `bus_rdata` one cycle later. In any cycle after one without `bus_rd`, `bus_rdata` is zero.
- R9: Reads of any offset not named in R2..R5 return zero. Writes to any offset other than 0x70 change nothing.
- R10: After reset the enable is 0, every counter and overflow bit is zero, and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | NUM_EVT | One line per event kind, counted each cycle it is high |
| cyc_qual | input | NUM_CYC | One line per latency kind, counted each cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that `bus_wr`, `bus_rd`, `bus_addr` and bit 1 of `bus_wdata` are known at every clock edge after reset. They also assume that the bus carries at most one write at a time, so that a clear is seen exactly on its write edge. The stimulus respects this. It changes every input on the falling edge and issues a single read or write per transaction task, with idle cycles between transactions. Event pulses and qualifiers are driven only from their own tasks, so a cycle that combines a clear with an event arises only where the test builds it on purpose.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int unsigned CTRL_OFS   = 32'h70;
  localparam int unsigned EOVF_OFS   = 32'h74;
  localparam int unsigned COVF_OFS   = 32'h78;
  localparam int unsigned EVT_BASE   = 32'h100;
  localparam int unsigned CYC_BASE   = 32'h180;
  localparam int unsigned EVT_STRIDE = 4;
  localparam int unsigned CYC_STRIDE = 8;
  localparam int unsigned HI_OFS     = 4;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned CLR_BIT    = 1;
endpackage

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank #(
  parameter int N = 15,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           clr,
  input  logic [N-1:0]   inc,
  output logic [N*W-1:0] cnt_flat,
  output logic [N-1:0]   ovf
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] c_q;
    logic         o_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        c_q <= '0;
        o_q <= 1'b0;
      end else if (en && inc[g]) begin
        c_q <= c_q + W'(1);
        if (&c_q) o_q <= 1'b1;
      end
    end
    assign cnt_flat[g*W +: W] = c_q;
    assign ovf[g]             = o_q;
  end
endmodule

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import perf_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en_bit,
  input  logic              wr_clr_bit,
  output logic              en_q,
  output logic              clr_pulse
);
  logic ctrl_hit;
  assign ctrl_hit  = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
  assign clr_pulse = ctrl_hit && wr_clr_bit;

  always_ff @(posedge clk) begin
    if (rst)           en_q <= 1'b0;
    else if (ctrl_hit) en_q <= wr_en_bit;
  end
endmodule

// File: rtl/perf_regmux.sv
module perf_regmux
  import perf_pkg::*;
#(
  parameter int NUM_EVT  = 15,
  parameter int EVT_W    = 32,
  parameter int NUM_CYC  = 6,
  parameter int CYC_W    = 48,
  parameter int CYC_LO_W = 32,
  parameter int ADDR_W   = 10
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     en,
  input  logic [NUM_EVT*EVT_W-1:0] evt_flat,
  input  logic [NUM_CYC*CYC_W-1:0] cyc_flat,
  input  logic [NUM_EVT-1:0]       evt_ovf,
  input  logic [NUM_CYC-1:0]       cyc_ovf,
  output logic [31:0]              word
);
  localparam int HI_W = CYC_W - CYC_LO_W;

  always_comb begin
    word = '0;
    if (addr == ADDR_W'(CTRL_OFS)) word[EN_BIT] = en;
    if (addr == ADDR_W'(EOVF_OFS)) word = 32'(evt_ovf);
    if (addr == ADDR_W'(COVF_OFS)) word = 32'(cyc_ovf);
    for (int i = 0; i < NUM_EVT; i++) begin
      if (addr == ADDR_W'(EVT_BASE + EVT_STRIDE * i))
        word = 32'(evt_flat[i*EVT_W +: EVT_W]);
    end
    for (int j = 0; j < NUM_CYC; j++) begin
      if (addr == ADDR_W'(CYC_BASE + CYC_STRIDE * j))
        word = 32'(cyc_flat[j*CYC_W +: CYC_LO_W]);
      if (addr == ADDR_W'(CYC_BASE + CYC_STRIDE * j + HI_OFS))
        word = 32'(cyc_flat[j*CYC_W + CYC_LO_W +: HI_W]);
    end
  end
endmodule

// File: rtl/l2_perf_unit.sv
module l2_perf_unit
  import perf_pkg::*;
#(
  parameter int NUM_EVT  = 15,
  parameter int EVT_W    = 32,
  parameter int NUM_CYC  = 6,
  parameter int CYC_W    = 48,
  parameter int CYC_LO_W = 32,
  parameter int ADDR_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_CYC-1:0] cyc_qual,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata
);
  logic                     en_q;
  logic                     clr_pulse;
  logic [NUM_EVT*EVT_W-1:0] evt_cnt_flat;
  logic [NUM_CYC*CYC_W-1:0] cyc_cnt_flat;
  logic [NUM_EVT-1:0]       evt_ovf;
  logic [NUM_CYC-1:0]       cyc_ovf;
  logic [31:0]              rd_word;
  logic                     unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:2];

  perf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wr_en_bit  (bus_wdata[EN_BIT]),
    .wr_clr_bit (bus_wdata[CLR_BIT]),
    .en_q       (en_q),
    .clr_pulse  (clr_pulse)
  );

  perf_cnt_bank #(.N(NUM_EVT), .W(EVT_W)) u_evt_bank (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .clr      (clr_pulse),
    .inc      (evt_pulse),
    .cnt_flat (evt_cnt_flat),
    .ovf      (evt_ovf)
  );

  perf_cnt_bank #(.N(NUM_CYC), .W(CYC_W)) u_cyc_bank (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .clr      (clr_pulse),
    .inc      (cyc_qual),
    .cnt_flat (cyc_cnt_flat),
    .ovf      (cyc_ovf)
  );

  perf_regmux #(
    .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .NUM_CYC(NUM_CYC),
    .CYC_W(CYC_W), .CYC_LO_W(CYC_LO_W), .ADDR_W(ADDR_W)
  ) u_mux (
    .addr     (bus_addr),
    .en       (en_q),
    .evt_flat (evt_cnt_flat),
    .cyc_flat (cyc_cnt_flat),
    .evt_ovf  (evt_ovf),
    .cyc_ovf  (cyc_ovf),
    .word     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/perf_chk.sv
module perf_chk
  import perf_pkg::*;
#(
  parameter int NUM_EVT  = 15,
  parameter int EVT_W    = 32,
  parameter int NUM_CYC  = 6,
  parameter int CYC_W    = 48,
  parameter int ADDR_W   = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wr,
  input logic                     clr_bit,
  input logic                     bus_rd,
  input logic [31:0]              bus_rdata,
  input logic                     en_q,
  input logic [NUM_EVT*EVT_W-1:0] evt_cnt,
  input logic [NUM_CYC*CYC_W-1:0] cyc_cnt,
  input logic [NUM_EVT-1:0]       evt_ovf,
  input logic [NUM_CYC-1:0]       cyc_ovf
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS)) && clr_bit;

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (evt_cnt == '0) && (cyc_cnt == '0) && (evt_ovf == '0) && (cyc_ovf == '0));

  a_r7_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !clr_wr) |=> $stable(evt_cnt) && $stable(cyc_cnt) && $stable(evt_ovf) && $stable(cyc_ovf));

  a_r5_evt_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((evt_ovf & $past(evt_ovf)) == $past(evt_ovf)));

  a_r5_cyc_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((cyc_ovf & $past(cyc_ovf)) == $past(cyc_ovf)));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  a_r9_low_unmapped: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr < ADDR_W'(CTRL_OFS))) |=> (bus_rdata == '0));

  a_r4_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(CTRL_OFS))) |=> (bus_rdata == {31'b0, $past(en_q)}));
endmodule

bind l2_perf_unit perf_chk #(
  .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .NUM_CYC(NUM_CYC),
  .CYC_W(CYC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .clr_bit   (bus_wdata[1]),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .en_q      (en_q),
  .evt_cnt   (evt_cnt_flat),
  .cyc_cnt   (cyc_cnt_flat),
  .evt_ovf   (evt_ovf),
  .cyc_ovf   (cyc_ovf)
);

// File: tb/l2_perf_unit_tb.sv
`timescale 1ns/1ps
module l2_perf_unit_tb;
  localparam int NUM_EVT = 15;
  localparam int EVT_W   = 8;
  localparam int NUM_CYC = 6;
  localparam int CYC_W   = 12;
  localparam int LO_W    = 8;
  localparam int ADDR_W  = 10;
  localparam int NVEC    = 6;
  // index, pulses, expected count (mod 256), expected overflow
  localparam int VEC [NVEC][4] = '{
    '{0, 1, 1, 0}, '{3, 5, 5, 0}, '{7, 255, 255, 0},
    '{9, 256, 0, 1}, '{14, 300, 44, 1}, '{12, 0, 0, 0}};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_EVT-1:0] evt_pulse = '0;
  logic [NUM_CYC-1:0] cyc_qual = '0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic               bus_wr = 1'b0;
  logic [31:0]        bus_wdata = '0;
  logic               bus_rd = 1'b0;
  logic [31:0]        bus_rdata;
  int                 checks = 0;
  int                 fails = 0;
  bit                 done = 1'b0;

  always #10 clk = ~clk;

  l2_perf_unit #(
    .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .NUM_CYC(NUM_CYC),
    .CYC_W(CYC_W), .CYC_LO_W(LO_W), .ADDR_W(ADDR_W)
  ) u_dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .cyc_qual(cyc_qual),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evt_pulse = NUM_EVT'(1) << idx;
    end
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic qual(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc_qual = NUM_CYC'(1) << idx;
    end
    @(negedge clk);
    cyc_qual = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 rdata", bus_rdata, 32'h0);
    rd(32'h70, d);  chk("R10 ctrl", d, 32'h0);
    rd(32'h100, d); chk("R10 evt0", d, 32'h0);
    rd(32'h78, d);  chk("R10 covf", d, 32'h0);

    // Table walk: R1 R2 R5
    for (int v = 0; v < NVEC; v++) begin
      wr(32'h70, 32'h3);
      pulse(VEC[v][0], VEC[v][1]);
      rd(32'h100 + 4 * VEC[v][0], d);
      chk("R1/R2 evt count", d, 32'(VEC[v][2]));
      rd(32'h74, d);
      chk("R5 evt ovf map", d, 32'(VEC[v][3]) << VEC[v][0]);
    end

    // R8 rdata zero after idle cycle
    @(negedge clk);
    chk("R8 idle rdata", bus_rdata, 32'h0);

    // R4 control readback, clear bit reads 0
    rd(32'h70, d); chk("R4 ctrl en", d, 32'h1);

    // R7 disabled: nothing counts
    wr(32'h70, 32'h2);
    pulse(2, 3);
    qual(1, 5);
    rd(32'h108, d); chk("R7 evt frozen", d, 32'h0);
    rd(32'h188, d); chk("R7 cyc frozen", d, 32'h0);
    rd(32'h70, d);  chk("R4 ctrl off", d, 32'h0);

    // R6 clear wins over same-cycle event
    wr(32'h70, 32'h1);
    pulse(1, 4);
    rd(32'h104, d); chk("R1 evt1 count", d, 32'h4);
    @(negedge clk);
    bus_addr = ADDR_W'(32'h70); bus_wdata = 32'h3; bus_wr = 1'b1; evt_pulse = 15'h2;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
    rd(32'h104, d); chk("R6 clear beats event", d, 32'h0);
    rd(32'h70, d);  chk("R6 enable kept", d, 32'h1);

    // R9 writes to counters ignored, unmapped reads zero
    pulse(4, 5);
    wr(32'h110, 32'hFF);
    wr(32'h74, 32'hFFFF);
    rd(32'h110, d); chk("R9 write ignored", d, 32'h5);
    rd(32'h74, d);  chk("R9 ovf write ignored", d, 32'h0);
    rd(32'h140, d); chk("R9 unmapped 0x140", d, 32'h0);
    rd(32'h1B0, d); chk("R9 unmapped 0x1B0", d, 32'h0);
    rd(32'h20, d);  chk("R9 unmapped 0x20", d, 32'h0);

    // R3 cycle counter split, carry into upper word
    wr(32'h70, 32'h3);
    qual(2, 300);
    rd(32'h190, d); chk("R3 cyc2 low", d, 32'h2C);
    rd(32'h194, d); chk("R3 cyc2 high", d, 32'h1);
    // R5 cycle overflow after full wrap
    qual(5, 4099);
    rd(32'h1A8, d); chk("R5 cyc5 low", d, 32'h3);
    rd(32'h1AC, d); chk("R5 cyc5 high", d, 32'h0);
    rd(32'h78, d);  chk("R5 cyc ovf map", d, 32'h20);
    rd(32'h190, d); chk("R3 cyc2 unchanged", d, 32'h2C);

    // R6 clear zeroes cycle side too
    wr(32'h70, 32'h3);
    rd(32'h78, d);  chk("R6 covf cleared", d, 32'h0);
    rd(32'h194, d); chk("R6 cyc2 high cleared", d, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule